// File: doc/BRIEF.md
# Two-Key Register Write Guard

This block sits in front of a peripheral register file and keeps its control registers from being modified by stray bus writes. After reset the guard is locked. Every bus write to an address other than the two kick registers is treated as a protected write and is forwarded to the register file through `prot_wr` only while the guard is open. Reads are never gated. The surrounding register file returns its data on `prot_rdata`, and the guard passes that data back to the bus.

To open the guard, software first writes the first 32-bit key to the kick register at offset 0x70. It then writes the second key to the kick register at offset 0x74, and the two writes must be directly back to back on the bus. The open state is reported in bit 23 of the control word read at offset 0x50. That bit rises only after a fixed settling delay of `SYNC_CYC` clock cycles, which stands in for a slow-domain handshake. Once open, the guard stays open until reset. Software that finds the bit already set skips the kick sequence.

Top module: `regfile_key_guard`

## Requirements
- R1: Reset (synchronous, active high) leaves the guard locked. After reset `unlocked` is 0, both kick registers read 0, and a protected write does not raise `prot_wr`.
- R2: While locked, a bus write to any address other than 0x70 and 0x74 leaves `prot_wr` at 0. A read at such an address returns `prot_rdata` unchanged.
- R3: Writing 32'h83E70B13 to 0x70 and then, on the very next bus write, 32'h95A4F1E0 to 0x74 opens the guard. `unlocked` and the status bit go to 1 exactly `SYNC_CYC` (default 4) clock edges after the edge that takes the second key. From the next cycle on, protected writes drive `prot_wr` to 1 in their own cycle. Repeating the first key before the second is allowed.
- R4: A wrong value written to 0x70, or a wrong value written to 0x74, returns the sequence to its start. A later lone write of the second key then does not open the guard.
- R5: A write of the second key to 0x74 that does not directly follow a correct first-key write does not open the guard. This covers the case where no first key was written and the case where another bus write came in between.
- R6: A read at 0x50 returns `prot_rdata` with bit 23 replaced by the open status (1 = open). All other bits come unchanged from `prot_rdata`.
- R7: Each kick register holds the last value written to it, in any state. It reads back at its own address, 0x70 or 0x74.
- R8: Once open, the guard ignores further kick writes of any value and stays open until reset.
- R9: During the settling delay, protected writes are still dropped. This includes a write in the last cycle before the status rises.
- R10: A write to 0x70 or 0x74 never raises `prot_wr`, whether the guard is locked or open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the current bus cycle |
| bus_addr | input | 8 | Byte offset of the current access |
| bus_wdata | input | 32 | Write data |
| prot_rdata | input | 32 | Read data from the protected register file |
| bus_rdata | output | 32 | Read data returned to the bus for `bus_addr` |
| prot_wr | output | 1 | Write enable passed to the protected register file |
| unlocked | output | 1 | Guard open status (also bit 23 at 0x50) |

## Verification
Two functions can fall in the same cycle: the settling delay expires, and a protected write arrives. The bench issues protected writes in every cycle after the second key. The write in the final settling cycle must be dropped, and the write one cycle later must be forwarded. Sequence breaks are provoked by putting an unrelated write between the two keys, by writing wrong values to either kick register, and by writing the second key alone. After each break, the status bit at 0x50 is read once the settling window has fully passed.

// File: rtl/keyguard_pkg.sv
package keyguard_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_K0 = 2'd0,
        ST_WAIT_K1 = 2'd1,
        ST_SETTLE  = 2'd2,
        ST_OPEN    = 2'd3
    } kg_state_e;

    // Decoded view of one bus cycle
    typedef struct packed {
        logic wr;
        logic hit_k0;
        logic hit_k1;
        logic hit_st;
        logic ok0;
        logic ok1;
    } kg_evt_t;

    // Next state of the key sequence checker
    function automatic kg_state_e seq_next(
        input kg_state_e cur,
        input logic      wr,
        input logic      hit0,
        input logic      hit1,
        input logic      ok0,
        input logic      ok1,
        input logic      cnt_zero
    );
        kg_state_e nxt;
        nxt = cur;
        case (cur)
            ST_WAIT_K0, ST_WAIT_K1: begin
                if (wr) begin
                    if (hit0)
                        nxt = ok0 ? ST_WAIT_K1 : ST_WAIT_K0;
                    else if (hit1 && ok1 && cur == ST_WAIT_K1)
                        nxt = ST_SETTLE;
                    else
                        nxt = ST_WAIT_K0;
                end
            end
            ST_SETTLE: if (cnt_zero) nxt = ST_OPEN;
            default:   nxt = ST_OPEN;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/kg_decode.sv
module kg_decode
    import keyguard_pkg::*;
#(
    parameter int              ADDR_W     = 8,
    parameter int              DATA_W     = 32,
    parameter logic [ADDR_W-1:0] K0_ADDR  = 8'h70,
    parameter logic [ADDR_W-1:0] K1_ADDR  = 8'h74,
    parameter logic [ADDR_W-1:0] ST_ADDR  = 8'h50,
    parameter logic [DATA_W-1:0] KEY0     = 32'h83E7_0B13,
    parameter logic [DATA_W-1:0] KEY1     = 32'h95A4_F1E0
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output kg_evt_t           evt
);
    always_comb begin
        evt.wr     = bus_wr;
        evt.hit_k0 = (bus_addr == K0_ADDR);
        evt.hit_k1 = (bus_addr == K1_ADDR);
        evt.hit_st = (bus_addr == ST_ADDR);
        evt.ok0    = (bus_wdata == KEY0);
        evt.ok1    = (bus_wdata == KEY1);
    end
endmodule

// File: rtl/kg_kick_regs.sv
module kg_kick_regs #(
    parameter int DATA_W = 32,
    parameter int N_KICK = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [N_KICK-1:0]             wr_hit,
    input  logic [DATA_W-1:0]             wdata,
    output logic [N_KICK-1:0][DATA_W-1:0] kick_q
);
    for (genvar i = 0; i < N_KICK; i++) begin : g_kick
        always_ff @(posedge clk) begin
            if (rst)
                kick_q[i] <= '0;
            else if (wr_hit[i])
                kick_q[i] <= wdata;
        end
    end
endmodule

// File: rtl/kg_seq.sv
module kg_seq
    import keyguard_pkg::*;
#(
    parameter int SYNC_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic hit0,
    input  logic hit1,
    input  logic ok0,
    input  logic ok1,
    output logic open_o
);
    localparam int CNT_W = (SYNC_CYC > 1) ? $clog2(SYNC_CYC) : 1;

    kg_state_e  state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    assign state_d = seq_next(state_q, wr, hit0, hit1, ok0, ok1, cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT_K0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_SETTLE && state_d == ST_SETTLE)
                cnt_q <= CNT_W'(SYNC_CYC - 1);
            else if (state_q == ST_SETTLE && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign open_o = (state_q == ST_OPEN);
endmodule

// File: rtl/kg_gate.sv
module kg_gate #(
    parameter int DATA_W   = 32,
    parameter int STAT_BIT = 23
) (
    input  logic              wr,
    input  logic              hit_k0,
    input  logic              hit_k1,
    input  logic              hit_st,
    input  logic              open_i,
    input  logic [DATA_W-1:0] kick0,
    input  logic [DATA_W-1:0] kick1,
    input  logic [DATA_W-1:0] prot_rdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              prot_wr
);
    logic [DATA_W-1:0] stat_word;

    always_comb begin
        stat_word           = prot_rdata;
        stat_word[STAT_BIT] = open_i;
    end

    always_comb begin
        if (hit_k0)      bus_rdata = kick0;
        else if (hit_k1) bus_rdata = kick1;
        else if (hit_st) bus_rdata = stat_word;
        else             bus_rdata = prot_rdata;
    end

    assign prot_wr = wr && open_i && !hit_k0 && !hit_k1;
endmodule

// File: rtl/regfile_key_guard.sv
module regfile_key_guard
    import keyguard_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] K0_ADDR  = 8'h70,
    parameter logic [ADDR_W-1:0] K1_ADDR  = 8'h74,
    parameter logic [ADDR_W-1:0] ST_ADDR  = 8'h50,
    parameter int                STAT_BIT = 23,
    parameter logic [DATA_W-1:0] KEY0     = 32'h83E7_0B13,
    parameter logic [DATA_W-1:0] KEY1     = 32'h95A4_F1E0,
    parameter int                SYNC_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] prot_rdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              prot_wr,
    output logic              unlocked
);
    localparam int N_KICK = 2;

    kg_evt_t                      evt;
    logic [N_KICK-1:0][DATA_W-1:0] kick_q;
    logic [N_KICK-1:0]            kick_wr;

    kg_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .K0_ADDR(K0_ADDR), .K1_ADDR(K1_ADDR), .ST_ADDR(ST_ADDR),
        .KEY0(KEY0), .KEY1(KEY1)
    ) u_dec (
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .evt(evt)
    );

    assign kick_wr = {evt.wr && evt.hit_k1, evt.wr && evt.hit_k0};

    kg_kick_regs #(.DATA_W(DATA_W), .N_KICK(N_KICK)) u_kick (
        .clk(clk), .rst(rst), .wr_hit(kick_wr), .wdata(bus_wdata), .kick_q(kick_q)
    );

    kg_seq #(.SYNC_CYC(SYNC_CYC)) u_seq (
        .clk(clk), .rst(rst), .wr(evt.wr),
        .hit0(evt.hit_k0), .hit1(evt.hit_k1),
        .ok0(evt.ok0), .ok1(evt.ok1),
        .open_o(unlocked)
    );

    kg_gate #(.DATA_W(DATA_W), .STAT_BIT(STAT_BIT)) u_gate (
        .wr(evt.wr), .hit_k0(evt.hit_k0), .hit_k1(evt.hit_k1), .hit_st(evt.hit_st),
        .open_i(unlocked), .kick0(kick_q[0]), .kick1(kick_q[1]),
        .prot_rdata(prot_rdata), .bus_rdata(bus_rdata), .prot_wr(prot_wr)
    );
endmodule

// File: rtl/keyguard_chk.sv
module keyguard_chk #(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] K0_ADDR  = 8'h70,
    parameter logic [ADDR_W-1:0] K1_ADDR  = 8'h74,
    parameter logic [ADDR_W-1:0] ST_ADDR  = 8'h50,
    parameter int                STAT_BIT = 23
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              prot_wr,
    input logic              unlocked
);
    logic is_kick;
    assign is_kick = (bus_addr == K0_ADDR) || (bus_addr == K1_ADDR);

    AST_RESET_LOCKED: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !unlocked);                                   // R1
    AST_LOCKED_NO_WR: assert property (@(posedge clk) disable iff (rst)
        !unlocked |-> !prot_wr);                                     // R2
    AST_OPEN_FORWARD: assert property (@(posedge clk) disable iff (rst)
        (unlocked && bus_wr && !is_kick) |-> prot_wr);               // R3
    AST_STATUS_BIT: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ST_ADDR) |-> (bus_rdata[STAT_BIT] == unlocked)); // R6
    AST_STAY_OPEN: assert property (@(posedge clk) disable iff (rst)
        unlocked |=> unlocked);                                      // R8
    AST_KICK_NO_WR: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && is_kick) |-> !prot_wr);                           // R10
endmodule

bind regfile_key_guard keyguard_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .K0_ADDR(K0_ADDR),
    .K1_ADDR(K1_ADDR), .ST_ADDR(ST_ADDR), .STAT_BIT(STAT_BIT)
) u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .prot_wr(prot_wr), .unlocked(unlocked)
);

// File: tb/regfile_key_guard_tb.sv
module regfile_key_guard_tb;
    localparam logic [31:0] K0 = 32'h83E7_0B13;
    localparam logic [31:0] K1 = 32'h95A4_F1E0;
    localparam logic [31:0] P  = 32'h0000_1234;

    typedef struct packed {
        logic [3:0]  req;
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] wd;
        logic [31:0] prd;
        logic        epw;
        logic [31:0] erd;
        logic        eul;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VEC [NV] = '{
        '{4'd2,  1'b1, 8'h10, 32'h5,        P,            1'b0, P,            1'b0}, // R2
        '{4'd7,  1'b1, 8'h70, K0,           P,            1'b0, 32'h0,        1'b0}, // R7 old value
        '{4'd5,  1'b1, 8'h10, 32'h7,        P,            1'b0, P,            1'b0}, // R5 break
        '{4'd10, 1'b1, 8'h74, K1,           P,            1'b0, 32'h0,        1'b0}, // R10
        '{4'd7,  1'b0, 8'h74, 32'h0,        P,            1'b0, K1,           1'b0}, // R7
        '{4'd5,  1'b0, 8'h10, 32'h0,        P,            1'b0, P,            1'b0},
        '{4'd5,  1'b0, 8'h10, 32'h0,        P,            1'b0, P,            1'b0},
        '{4'd5,  1'b0, 8'h10, 32'h0,        P,            1'b0, P,            1'b0},
        '{4'd5,  1'b0, 8'h10, 32'h0,        P,            1'b0, P,            1'b0},
        '{4'd5,  1'b0, 8'h50, 32'h0,        32'hFFFFFFFF, 1'b0, 32'hFF7FFFFF, 1'b0}, // R5
        '{4'd5,  1'b1, 8'h74, K1,           P,            1'b0, K1,           1'b0}, // R5 lone key1
        '{4'd4,  1'b1, 8'h70, 32'h83E70B12, P,            1'b0, K0,           1'b0}, // R4
        '{4'd4,  1'b1, 8'h74, K1,           P,            1'b0, K1,           1'b0}, // R4
        '{4'd4,  1'b1, 8'h70, K0,           P,            1'b0, 32'h83E70B12, 1'b0},
        '{4'd4,  1'b1, 8'h74, 32'h95A4F1E1, P,            1'b0, K1,           1'b0}, // R4
        '{4'd5,  1'b1, 8'h74, K1,           P,            1'b0, 32'h95A4F1E1, 1'b0},
        '{4'd4,  1'b0, 8'h10, 32'h0,        P,            1'b0, P,            1'b0},
        '{4'd4,  1'b0, 8'h10, 32'h0,        P,            1'b0, P,            1'b0},
        '{4'd4,  1'b0, 8'h10, 32'h0,        P,            1'b0, P,            1'b0},
        '{4'd4,  1'b0, 8'h10, 32'h0,        P,            1'b0, P,            1'b0},
        '{4'd4,  1'b0, 8'h50, 32'h0,        32'hFFFFFFFF, 1'b0, 32'hFF7FFFFF, 1'b0}, // R4
        '{4'd3,  1'b1, 8'h70, K0,           P,            1'b0, K0,           1'b0}, // R3
        '{4'd3,  1'b1, 8'h74, K1,           P,            1'b0, K1,           1'b0}, // R3
        '{4'd9,  1'b1, 8'h20, 32'h1,        P,            1'b0, P,            1'b0}, // R9
        '{4'd9,  1'b0, 8'h10, 32'h0,        P,            1'b0, P,            1'b0},
        '{4'd9,  1'b0, 8'h50, 32'h0,        32'h0,        1'b0, 32'h0,        1'b0}, // R9
        '{4'd9,  1'b1, 8'h20, 32'h2,        P,            1'b0, P,            1'b0}, // R9 last
        '{4'd3,  1'b1, 8'h20, 32'h3,        P,            1'b1, P,            1'b1}, // R3
        '{4'd6,  1'b0, 8'h50, 32'h0,        32'h0,        1'b0, 32'h00800000, 1'b1}, // R6
        '{4'd6,  1'b0, 8'h50, 32'h0,        32'hFFFFFFFF, 1'b0, 32'hFFFFFFFF, 1'b1}, // R6
        '{4'd10, 1'b1, 8'h70, 32'h0,        P,            1'b0, K0,           1'b1}, // R10 R8
        '{4'd8,  1'b1, 8'h74, 32'h0,        P,            1'b0, K1,           1'b1}, // R8
        '{4'd8,  1'b1, 8'h30, 32'h9,        P,            1'b1, P,            1'b1}, // R8
        '{4'd7,  1'b0, 8'h70, 32'h0,        P,            1'b0, 32'h0,        1'b1}  // R7
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] prot_rdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        prot_wr;
    logic        unlocked;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    regfile_key_guard u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .prot_rdata(prot_rdata), .bus_rdata(bus_rdata),
        .prot_wr(prot_wr), .unlocked(unlocked)
    );

    task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One bus cycle: drive after negedge, sample before the next posedge
    task automatic cyc(input vec_t v);
        @(negedge clk);
        bus_wr     = v.wr;
        bus_addr   = v.addr;
        bus_wdata  = v.wd;
        prot_rdata = v.prd;
        #4;
        chk(int'(v.req), "prot_wr",   {31'd0, prot_wr},  {31'd0, v.epw});
        chk(int'(v.req), "bus_rdata", bus_rdata,         v.erd);
        chk(int'(v.req), "unlocked",  {31'd0, unlocked}, {31'd0, v.eul});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        cyc('{4'd1, 1'b0, 8'h70, 32'h0, P, 1'b0, 32'h0, 1'b0});
        cyc('{4'd1, 1'b1, 8'h20, 32'h1, P, 1'b0, P,     1'b0});

        for (int i = 0; i < NV; i++) cyc(VEC[i]);

        // R1: reset while open returns to locked, clears kicks
        @(negedge clk);
        rst = 1'b1; bus_wr = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        cyc('{4'd1, 1'b0, 8'h74, 32'h0, P, 1'b0, 32'h0, 1'b0});
        cyc('{4'd1, 1'b1, 8'h20, 32'h4, P, 1'b0, P,     1'b0});
        cyc('{4'd1, 1'b0, 8'h70, 32'h0, P, 1'b0, 32'h0, 1'b0});

        // R3: repeated first key then second key still opens
        cyc('{4'd3, 1'b1, 8'h70, K0, P, 1'b0, 32'h0, 1'b0});
        cyc('{4'd3, 1'b1, 8'h70, K0, P, 1'b0, K0,    1'b0});
        cyc('{4'd3, 1'b1, 8'h74, K1, P, 1'b0, 32'h0, 1'b0});
        for (int j = 0; j < 4; j++)
            cyc('{4'd9, 1'b1, 8'h40, 32'h0, P, 1'b0, P, 1'b0});
        cyc('{4'd3, 1'b1, 8'h40, 32'h0, P, 1'b1, P, 1'b1});

        bus_wr = 1'b0;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule